// File: doc/BRIEF.md
# Banked GPIO Pin Register File

This block is the register side of a general-purpose I/O controller whose pins are grouped into banks. Each bank owns two full-word registers: one holds the values the bank drives onto its pins, the other selects which pins are inputs and which are outputs. A small request/response register bus reads and writes these registers. The block drives per-pin output values and output enables, and it synchronizes the raw pin inputs before software can read them.

Bank bases sit on an 8-byte stride that starts at offset 0x08. The window 0x90 to 0x9F belongs to a separate interrupt unit, so any bank whose base would land at or above 0x90 is moved up by 0x10. The address map therefore has a gap. The pin count and the lines per bank are parameters. The bank count is the pin count divided by the lines per bank, rounded up, so the last bank may be only partly populated.

Top module: `gpio_bank_regs`

## Requirements
- R1: Bank b (counting from 0) has base (b+1)*8; its drive-value register is at base+0 and its direction register at base+4.
- R2: A computed base at or above 0x90 is raised by 0x10, so offsets 0x90, 0x94, 0x98 and 0x9C map to no register, and the bank that would sit at 0x90 answers at 0xA0.
- R3: Direction bit value 1 makes the pin an input (`pin_oe` bit 0); value 0 makes it an output (`pin_oe` bit 1). `pin_out` always carries the stored drive-value bit.
- R4: Reading the drive-value register returns, per line, the synchronized pin level for input lines and the stored drive value for output lines.
- R5: A pin level present at clock edge k is returned by reads accepted at edge k+2 or later. Reads accepted at edges k and k+1 still return the previous level.
- R6: After reset every direction bit is 1, every drive-value bit is 0, and `pin_oe` and `pin_out` are all zero.
- R7: A read of an unmapped address returns zero. A write to an unmapped address changes no register and no pin.
- R8: Register bits at and above the lines-per-bank width, and lines beyond the pin count in the last bank, always read as zero and cannot be set.
- R9: The bank count is the pin count divided by the lines per bank, rounded up. With 155 pins and 8 lines the last bank sits at 0xB0/0xB4 and holds 3 lines.
- R10: `req_ready` is high whenever the synchronized reset is released. A read is accepted on an edge where `req_valid` and `req_ready` are both high, and `rsp_valid` is high for exactly the following cycle. Writes produce no response.
- R11: A write replaces the whole addressed register with the low bits of `req_wdata`. The new value is on the pins right after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | NUM_PINS | Raw pin levels |
| pin_out | output | NUM_PINS | Drive values |
| pin_oe | output | NUM_PINS | Output enables, 1 = drive |

## Verification
Several properties are checked on every cycle. The decoder never selects more than one register. A direction write lands on `pin_oe` with the correct polarity, and a drive-value write lands on `pin_out`. Responses follow accepted reads one to one. Unmapped reads and unused high bits read zero. Other behaviour can only be shown by the bench's scenarios. These are the exact two-edge latency of the input synchronizer, the mixed input/output read-back, and the absence of side effects from writes into the reserved window. The gap in the map and the partial last bank only appear with a 155-pin instance, so the bench builds one.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

  localparam int unsigned BUS_W = 32;
  localparam logic [BUS_W-1:0] BANK_STRIDE = 32'h8;
  localparam logic [BUS_W-1:0] HOLE_START  = 32'h90;
  localparam logic [BUS_W-1:0] HOLE_SIZE   = 32'h10;
  localparam logic [BUS_W-1:0] OFS_VALUE   = 32'h0;
  localparam logic [BUS_W-1:0] OFS_DIR     = 32'h4;

  // Base byte address of bank b, stepping over the interrupt window.
  function automatic logic [BUS_W-1:0] bank_base(input int unsigned b);
    logic [BUS_W-1:0] r;
    r = (BUS_W'(b) + 32'd1) * BANK_STRIDE;
    if (r >= HOLE_START) r = r + HOLE_SIZE;
    return r;
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode #(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          addr,
  output logic [NUM_BANKS-1:0] value_hit,
  output logic [NUM_BANKS-1:0] dir_hit
);
  import gpio_regs_pkg::*;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cmp
    localparam logic [BUS_W-1:0] BASE = bank_base(g);
    assign value_hit[g] = (addr == BASE + OFS_VALUE);
    assign dir_hit[g]   = (addr == BASE + OFS_DIR);
  end

  // R1: at most one register is selected by any address
  assert_single_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({value_hit, dir_hit}));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, meta_d;
  logic [WIDTH-1:0] stab_q, stab_d;

  always_comb begin
    meta_d = raw_i;
    stab_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
    end
  end

  assign sync_o = stab_q;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int unsigned LINES  = 8,
  parameter int unsigned ACTIVE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_value,
  input  logic             wr_dir,
  input  logic [LINES-1:0] wdata,
  input  logic [LINES-1:0] sync_in,
  output logic [LINES-1:0] value_rd,
  output logic [LINES-1:0] dir_rd,
  output logic [LINES-1:0] out_o,
  output logic [LINES-1:0] oe_o
);
  localparam logic [LINES-1:0] MASK =
    (ACTIVE >= LINES) ? {LINES{1'b1}} : LINES'((64'd1 << ACTIVE) - 64'd1);

  logic [LINES-1:0] drv_q, drv_d;
  logic [LINES-1:0] dir_q, dir_d;
  logic             drv_en, dir_en;

  always_comb begin
    drv_en = wr_value;
    dir_en = wr_dir;
    drv_d  = wdata & MASK;
    dir_d  = wdata & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= '0;
      dir_q <= MASK;
    end else begin
      if (drv_en) drv_q <= drv_d;
      if (dir_en) dir_q <= dir_d;
    end
  end

  assign value_rd = ((dir_q & sync_in) | (~dir_q & drv_q)) & MASK;
  assign dir_rd   = dir_q;
  assign out_o    = drv_q;
  assign oe_o     = ~dir_q & MASK;

  // R3: a direction write shows on the output enables with inverted polarity
  assert_oe_polarity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (oe_o == (~$past(wdata) & MASK)));

  // R11: a value write is on the pins after the accepting edge
  assert_value_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_value |=> (out_o == ($past(wdata) & MASK)));

  // R7: without a write the pin drive holds
  assert_hold_without_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_value && !wr_dir) |=> ($stable(out_o) && $stable(oe_o)));

  // R8: unpopulated lines never drive
  assert_unpopulated_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_o & ~MASK) == '0) && ((value_rd & ~MASK) == '0));

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int unsigned LINES_PER_BANK = 8,
  parameter int unsigned NUM_PINS       = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [31:0]         req_addr,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  output logic [31:0]         rsp_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  localparam int unsigned L         = LINES_PER_BANK;
  localparam int unsigned NUM_BANKS = (NUM_PINS + L - 1) / L;
  localparam int unsigned PAD_PINS  = NUM_BANKS * L;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  logic irst_n;
  assign irst_n    = rst_sync_q;
  assign req_ready = rst_sync_q;

  // request qualification
  logic rd_acc, wr_acc;
  assign rd_acc = req_valid & req_ready & ~req_write;
  assign wr_acc = req_valid & req_ready &  req_write;

  // address decode
  logic [NUM_BANKS-1:0] value_hit, dir_hit;
  gpio_addr_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
    .clk       (clk),
    .rst_n     (irst_n),
    .addr      (req_addr),
    .value_hit (value_hit),
    .dir_hit   (dir_hit)
  );
  logic hit_any;
  assign hit_any = |{value_hit, dir_hit};

  // input synchronizer
  logic [NUM_PINS-1:0] sync_in;
  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (irst_n),
    .raw_i  (pin_in),
    .sync_o (sync_in)
  );

  logic [PAD_PINS-1:0] sync_pad;
  always_comb begin
    sync_pad = '0;
    sync_pad[NUM_PINS-1:0] = sync_in;
  end

  // banks
  logic [PAD_PINS-1:0] out_pad, oe_pad;
  logic [L-1:0]        bank_value_rd [NUM_BANKS];
  logic [L-1:0]        bank_dir_rd   [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam int unsigned ACT =
      ((NUM_PINS - g * L) >= L) ? L : (NUM_PINS - g * L);
    gpio_bank #(.LINES(L), .ACTIVE(ACT)) u_bank (
      .clk      (clk),
      .rst_n    (irst_n),
      .wr_value (wr_acc & value_hit[g]),
      .wr_dir   (wr_acc & dir_hit[g]),
      .wdata    (req_wdata[L-1:0]),
      .sync_in  (sync_pad[g*L +: L]),
      .value_rd (bank_value_rd[g]),
      .dir_rd   (bank_dir_rd[g]),
      .out_o    (out_pad[g*L +: L]),
      .oe_o     (oe_pad[g*L +: L])
    );
  end

  assign pin_out = out_pad[NUM_PINS-1:0];
  assign pin_oe  = oe_pad[NUM_PINS-1:0];

  if (PAD_PINS > NUM_PINS) begin : g_pad_unused
    logic unused_pad_bits;
    assign unused_pad_bits = ^{out_pad[PAD_PINS-1:NUM_PINS], oe_pad[PAD_PINS-1:NUM_PINS]};
  end
  if (L < 32) begin : g_wdata_unused
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^req_wdata[31:L];
  end

  // read path: next state
  logic [L-1:0]  rd_sel;
  logic [31:0]   rdata_d;
  logic          rvalid_d;
  logic          rdata_en;
  always_comb begin
    rd_sel = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (value_hit[b]) rd_sel = rd_sel | bank_value_rd[b];
      if (dir_hit[b])   rd_sel = rd_sel | bank_dir_rd[b];
    end
    rdata_d         = '0;
    rdata_d[L-1:0]  = rd_sel;
    rvalid_d        = rd_acc;
    rdata_en        = rd_acc;
  end

  // read path: registers
  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rvalid_d;
      if (rdata_en) rsp_rdata <= rdata_d;
    end
  end

  // R10: every accepted read gets exactly one response cycle
  assert_rsp_follows_read_R10: assert property (@(posedge clk) disable iff (!irst_n)
    rd_acc |=> rsp_valid);
  assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!irst_n)
    !rd_acc |=> !rsp_valid);

  // R7: unmapped reads return zero
  assert_unmapped_reads_zero_R7: assert property (@(posedge clk) disable iff (!irst_n)
    (rd_acc && !hit_any) |=> (rsp_rdata == 32'h0));

  // R8: bits above the bank width never read as one
  if (L < 32) begin : g_hi_zero
    assert_high_bits_zero_R8: assert property (@(posedge clk) disable iff (!irst_n)
      rsp_valid |-> (rsp_rdata[31:L] == '0));
  end

endmodule

// File: tb/test_gpio_bank_regs.sv
module test_gpio_bank_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int WPINS = 155;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        s_valid = 1'b0, w_valid = 1'b0;
  logic        b_write = 1'b0;
  logic [31:0] b_addr = '0, b_wdata = '0;

  logic        s_ready, s_rsp_valid;
  logic [31:0] s_rdata;
  logic [31:0] s_pin_in = '0;
  logic [31:0] s_pin_out, s_pin_oe;

  logic        w_ready, w_rsp_valid;
  logic [31:0] w_rdata;
  logic [WPINS-1:0] w_pin_in = '0;
  logic [WPINS-1:0] w_pin_out, w_pin_oe;

  gpio_bank_regs #(.LINES_PER_BANK(8), .NUM_PINS(32)) i_gpio_bank_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(s_valid), .req_ready(s_ready),
    .req_write(b_write), .req_addr(b_addr), .req_wdata(b_wdata),
    .rsp_valid(s_rsp_valid), .rsp_rdata(s_rdata),
    .pin_in(s_pin_in), .pin_out(s_pin_out), .pin_oe(s_pin_oe));

  gpio_bank_regs #(.LINES_PER_BANK(8), .NUM_PINS(WPINS)) i_gpio_bank_regs_wide (
    .clk(clk), .rst_n(rst_n), .req_valid(w_valid), .req_ready(w_ready),
    .req_write(b_write), .req_addr(b_addr), .req_wdata(b_wdata),
    .rsp_valid(w_rsp_valid), .rsp_rdata(w_rdata),
    .pin_in(w_pin_in), .pin_out(w_pin_out), .pin_oe(w_pin_oe));

  int tests = 0;
  int fails = 0;

  // model of the small instance
  logic [7:0] m_val [NB];
  logic [7:0] m_dir [NB];

  function automatic logic [31:0] base_of(int b);
    logic [31:0] r;
    r = (b + 1) * 8;
    if (r >= 32'h90) r = r + 32'h10;
    return r;
  endfunction

  function automatic logic [31:0] exp_read(logic [31:0] a);
    for (int b = 0; b < NB; b++) begin
      if (a == base_of(b))
        return {24'h0, (m_dir[b] & s_pin_in[b*8 +: 8]) | (~m_dir[b] & m_val[b])};
      if (a == base_of(b) + 4) return {24'h0, m_dir[b]};
    end
    return 32'h0;
  endfunction

  function automatic logic [31:0] exp_oe();
    logic [31:0] r;
    for (int b = 0; b < NB; b++) r[b*8 +: 8] = ~m_dir[b];
    return r;
  endfunction

  function automatic logic [31:0] exp_out();
    logic [31:0] r;
    for (int b = 0; b < NB; b++) r[b*8 +: 8] = m_val[b];
    return r;
  endfunction

  function automatic void model_write(logic [31:0] a, logic [31:0] d);
    for (int b = 0; b < NB; b++) begin
      if (a == base_of(b)) m_val[b] = d[7:0];
      if (a == base_of(b) + 4) m_dir[b] = d[7:0];
    end
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // tasks are entered and left at a falling edge
  task automatic bus_wr(input bit wide, input logic [31:0] a, input logic [31:0] d);
    s_valid = !wide; w_valid = wide; b_write = 1'b1; b_addr = a; b_wdata = d;
    @(posedge clk); @(negedge clk);
    s_valid = 1'b0; w_valid = 1'b0; b_write = 1'b0;
  endtask

  task automatic bus_rd(input bit wide, input logic [31:0] a, output logic [31:0] d, output logic v);
    s_valid = !wide; w_valid = wide; b_write = 1'b0; b_addr = a;
    @(posedge clk); @(negedge clk);
    s_valid = 1'b0; w_valid = 1'b0;
    d = wide ? w_rdata : s_rdata;
    v = wide ? w_rsp_valid : s_rsp_valid;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd, a, d;
    logic v;
    void'($urandom(32'd1234));
    for (int b = 0; b < NB; b++) begin m_val[b] = 8'h00; m_dir[b] = 8'hFF; end

    repeat (3) @(negedge clk);
    chk("R10 ready low in reset", {255'h0, s_ready}, 256'h0);
    rst_n = 1'b1;
    idle(3);
    chk("R10 ready after reset", {254'h0, s_ready, w_ready}, 256'h3);

    // R6 reset state
    chk("R6 pin_oe reset", s_pin_oe, 256'h0);
    chk("R6 pin_out reset", s_pin_out, 256'h0);
    for (int b = 0; b < NB; b++) begin
      bus_rd(0, base_of(b) + 4, rd, v);
      chk("R6 dir reset", rd, 256'hFF);
      bus_rd(0, base_of(b), rd, v);
      chk("R6 value reset", rd, 256'h0);
    end

    // R1 map and R10 response timing
    bus_rd(0, 32'h0C, rd, v);
    chk("R10 rsp_valid after read", {255'h0, v}, 256'h1);
    idle(1);
    chk("R10 rsp_valid one cycle", {255'h0, s_rsp_valid}, 256'h0);
    bus_wr(0, 32'h14, 32'h0000_00F0);
    model_write(32'h14, 32'h0000_00F0);
    chk("R10 no rsp on write", {255'h0, s_rsp_valid}, 256'h0);
    chk("R3 oe after dir write", s_pin_oe, exp_oe());
    bus_wr(0, 32'h10, 32'hFFFF_FF5A);
    model_write(32'h10, 32'hFFFF_FF5A);
    chk("R11 pin_out after write", s_pin_out, exp_out());
    bus_rd(0, 32'h10, rd, v);
    chk("R1 R4 bank1 mixed readback", rd, exp_read(32'h10));
    bus_rd(0, 32'h14, rd, v);
    chk("R8 dir upper bits zero", rd, 256'hF0);

    // R5 synchronizer latency: bank0 inputs
    s_pin_in[7:0] = 8'hA5;
    bus_rd(0, 32'h08, rd, v);
    chk("R5 read at edge k old", rd, 256'h00);
    bus_rd(0, 32'h08, rd, v);
    chk("R5 read at edge k+1 old", rd, 256'h00);
    bus_rd(0, 32'h08, rd, v);
    chk("R5 read at edge k+2 new", rd, 256'hA5);

    // R7 unmapped access
    bus_wr(0, 32'h28, 32'hFFFF_FFFF);
    bus_wr(0, 32'h00, 32'h0000_0000);
    bus_wr(0, 32'h0A, 32'h0000_0000);
    chk("R7 pins unchanged after unmapped write", {s_pin_out, s_pin_oe}, {exp_out(), exp_oe()});
    bus_rd(0, 32'h28, rd, v);
    chk("R7 unmapped read zero", rd, 256'h0);
    bus_rd(0, 32'h08 + 32'h1, rd, v);
    chk("R7 misaligned read zero", rd, 256'h0);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 6) a = base_of($urandom_range(0, NB - 1)) + ($urandom_range(0, 1) * 4);
      else if (sel < 8) a = {24'h0, 6'($urandom_range(0, 63)), 2'b00};
      else a = $urandom;
      d = $urandom;
      if (i % 40 == 39) begin
        s_pin_in = $urandom;
        idle(3);
      end
      if ($urandom_range(0, 1) == 1) begin
        bus_wr(0, a, d);
        model_write(a, d);
        chk("R11 R3 random pins", {s_pin_out, s_pin_oe}, {exp_out(), exp_oe()});
      end else begin
        bus_rd(0, a, rd, v);
        chk("R4 R7 random read", {v, rd}, {1'b1, exp_read(a)});
      end
    end

    // wide instance: address gap and partial last bank
    bus_rd(1, 32'hB4, rd, v);
    chk("R9 last bank dir reset width", rd, 256'h07);
    bus_wr(1, 32'hB4, 32'h0);
    bus_rd(1, 32'hB4, rd, v);
    chk("R9 last bank dir cleared", rd, 256'h0);
    chk("R9 last bank oe", {253'h0, w_pin_oe[154:152]}, 256'h7);
    bus_wr(1, 32'hB0, 32'hFFFF_FFFF);
    bus_rd(1, 32'hB0, rd, v);
    chk("R8 last bank value masked", rd, 256'h07);
    chk("R8 last bank pin_out", {253'h0, w_pin_out[154:152]}, 256'h7);
    for (int k = 0; k < 4; k++) bus_wr(1, 32'h90 + k * 4, 32'h5A);
    for (int k = 0; k < 4; k++) begin
      bus_rd(1, 32'h90 + k * 4, rd, v);
      chk("R2 reserved window reads zero", rd, 256'h0);
    end
    bus_rd(1, 32'hA4, rd, v);
    chk("R2 shifted bank dir untouched", rd, 256'hFF);
    bus_rd(1, 32'h8C, rd, v);
    chk("R2 bank below gap dir untouched", rd, 256'hFF);
    chk("R2 no pins driven by reserved write", w_pin_oe[143:0], 256'h0);
    bus_wr(1, 32'hA4, 32'h0F);
    bus_wr(1, 32'hA0, 32'h3C);
    bus_rd(1, 32'hA0, rd, v);
    chk("R2 R4 shifted bank readback", rd, 256'h30);
    chk("R2 shifted bank pins", {w_pin_out[143:136], w_pin_oe[143:136]}, 256'h3CF0);
    bus_wr(1, 32'h88, 32'h81);
    chk("R1 bank16 value", w_pin_out[135:128], 256'h81);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule